// File: doc/BRIEF.md
# Receive Buffer with Per-Character Error Tags

This block queues the characters that a UART receiver has assembled until the host takes them. Each stored entry carries the 8-bit character and three tag bits: a parity error, a framing error and a break condition. The host sees the oldest entry at the read side at all times and removes it with a one-cycle pop strobe. An occupancy count, a trigger flag against one of four selectable thresholds, and a summary bit are provided alongside the data. The summary bit stays high for as long as any tagged entry is still queued.

In buffered mode the queue holds `DEPTH` entries (64 by default). With buffering turned off it shrinks to a single holding slot. A DMA receive-ready output has two behaviours. In the single-transfer behaviour it is high while anything is queued. In the block-transfer behaviour it rises at the trigger threshold and stays high until the queue has drained. A clear strobe empties the queue in buffered mode. Any change of the buffering mode also empties it.

Top module: `rxq_errtag_fifo`

## Requirements
- R1: After reset `level` is 0 and `rd_avail`, `any_err`, `overrun` and `rx_ready` are 0.
- R2: In buffered mode (`fifo_en`=1) up to DEPTH (64) entries are kept and returned in arrival order. `rd_data`/`rd_perr`/`rd_ferr`/`rd_brk` show the oldest entry while `rd_avail`=1. `level` changes on the clock edge that samples `wr_valid` or `rd_pop`. A push and a pop in the same cycle leave `level` unchanged.
- R3: A write while `level` equals the capacity is discarded and leaves the stored entries unchanged. It sets `overrun` on the next edge. `overrun` stays high until an entry is popped, a clear takes effect or the mode changes. If a set and a pop fall in the same cycle, the set wins.
- R4: `rd_pop` while the queue is empty has no effect on `level` or on the contents.
- R5: `any_err` is 1 exactly while at least one queued entry has any of its three tag bits set.
- R6: `trig_hit` is 1 when `level` is at least the threshold chosen by `trig_sel`. In buffered mode the encodings are 0 → DEPTH/8 (8), 1 → DEPTH/4 (16), 2 → DEPTH/2 (32) and 3 → DEPTH−DEPTH/8 (56). In single-slot mode the threshold is 1.
- R7: `clr_strobe` with `fifo_en`=1 empties the queue and clears `any_err` and `overrun` on the next edge. With `fifo_en`=0 it is ignored.
- R8: With `fifo_en`=0 the capacity is one entry, so a second write without a pop is an overrun.
- R9: A change of `fifo_en` empties the queue on the next edge. A write in that same cycle is dropped.
- R10: With `dma_mode`=0, or in single-slot mode, `rx_ready` equals (`level` ≠ 0).
- R11: With `dma_mode`=1 in buffered mode, `rx_ready` rises when `level` reaches the threshold. It stays high as `level` falls below the threshold and drops only when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | 1: buffered mode of DEPTH entries; 0: single holding slot |
| dma_mode | input | 1 | 0: ready on any data; 1: ready from threshold until empty |
| trig_sel | input | 2 | Threshold select (see R6) |
| clr_strobe | input | 1 | Empty the queue (buffered mode only) |
| wr_valid | input | 1 | Receiver delivers an entry this cycle |
| wr_data | input | 8 | Received character |
| wr_perr | input | 1 | Parity error tag of the character |
| wr_ferr | input | 1 | Framing error tag of the character |
| wr_brk | input | 1 | Break tag of the character |
| rd_pop | input | 1 | Host removes the oldest entry |
| rd_avail | output | 1 | At least one entry queued |
| rd_data | output | 8 | Oldest character |
| rd_perr | output | 1 | Parity tag of the oldest entry |
| rd_ferr | output | 1 | Framing tag of the oldest entry |
| rd_brk | output | 1 | Break tag of the oldest entry |
| level | output | 7 | Number of queued entries (0..DEPTH) |
| trig_hit | output | 1 | Occupancy at or above the selected threshold |
| any_err | output | 1 | Some queued entry carries a tag |
| overrun | output | 1 | A write was lost because the queue was full |
| rx_ready | output | 1 | DMA receive-ready |

## Verification
The bench fills the queue to capacity and writes once more. A design that wrapped its pointer would overwrite the oldest entry, and the returned order would then disagree with the scoreboard. A tagged entry is placed between clean ones so that `any_err` must survive the pop of a clean neighbour and fall on the pop of the tagged entry itself. A simple flag cleared on any pop, or set only by the latest write, fails this. The block-transfer ready is checked just below the threshold, at the threshold, after draining part-way and at empty. A version that simply compares against the threshold would drop `rx_ready` too early. The bench also checks that a clear in single-slot mode keeps the stored character, and that a mode switch discards the whole queue.

// File: rtl/rxq_pkg.sv
// Shared types for the tagged receive queue.
// Assumes 8-bit characters unless RXQ_DW is changed for the whole chip.
package rxq_pkg;
    parameter int RXQ_DW = 8;

    // One queued character with its three error tags.
    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [RXQ_DW-1:0] data;
    } rxq_entry_t;

    // True when an entry carries any error tag.
    function automatic logic rxq_tagged(rxq_entry_t e);
        return e.brk | e.ferr | e.perr;
    endfunction

    // Threshold for a trigger select code, never below one entry.
    function automatic int rxq_threshold(int sel, int depth);
        int t;
        case (sel)
            0:       t = depth / 8;
            1:       t = depth / 4;
            2:       t = depth / 2;
            default: t = depth - depth / 8;
        endcase
        return (t < 1) ? 1 : t;
    endfunction
endpackage

// File: rtl/rxq_store.sv
// Circular storage with read/write pointers and an occupancy count.
// Assumes the caller never pushes when full nor pops when empty; flush wins.
module rxq_store
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  rxq_entry_t    wr_entry,
    output rxq_entry_t    rd_entry,
    output logic [LW-1:0] level
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;

    // Write the incoming entry into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wr_entry;
        end
    end

    // Advance or clear the pointers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
        end
    end

    // Track how many entries are held.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            level <= '0;
        end else if (push && !pop) begin
            level <= level + 1'b1;
        end else if (pop && !push) begin
            level <= level - 1'b1;
        end
    end

    // Show-ahead read of the oldest entry.
    always_comb begin
        rd_entry = mem[rptr];
    end
endmodule

// File: rtl/rxq_errcount.sv
// Counts queued entries that carry an error tag; drives the summary bit.
// Assumes push/pop are the qualified strobes used by the storage.
module rxq_errcount #(
    parameter  int DEPTH = 64,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic push_tagged,
    input  logic pop_tagged,
    output logic any_err
);
    logic [LW-1:0] cnt;

    // Raise on a tagged push, lower on a tagged pop.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt <= '0;
        end else if (push_tagged && !pop_tagged) begin
            cnt <= cnt + 1'b1;
        end else if (pop_tagged && !push_tagged) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Summary is high while any tagged entry remains.
    always_comb begin
        any_err = (cnt != '0);
    end
endmodule

// File: rtl/rxq_dmaready.sv
// Trigger compare and DMA receive-ready generation for both modes.
// Assumes level is the registered occupancy from the storage.
module rxq_dmaready
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int LW    = $clog2(DEPTH + 1),
    localparam int NSEL  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          fifo_en,
    input  logic          dma_mode,
    input  logic [1:0]    trig_sel,
    input  logic [LW-1:0] level,
    output logic          trig_hit,
    output logic          rx_ready
);
    logic [LW-1:0] thr_tab [NSEL];
    logic [LW-1:0] thr;
    logic          nonempty;
    logic          held;

    // Build the threshold table from the depth.
    for (genvar g = 0; g < NSEL; g++) begin : g_thr
        assign thr_tab[g] = LW'(rxq_threshold(g, DEPTH));
    end

    // Pick the threshold; one entry in single-slot mode.
    always_comb begin
        thr      = fifo_en ? thr_tab[trig_sel] : LW'(1);
        trig_hit = (level >= thr);
        nonempty = (level != '0);
    end

    // Remember that the threshold was reached until the queue drains.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || !nonempty) begin
            held <= 1'b0;
        end else if (trig_hit) begin
            held <= 1'b1;
        end
    end

    // Select the ready behaviour.
    always_comb begin
        if (fifo_en && dma_mode) begin
            rx_ready = trig_hit || (held && nonempty);
        end else begin
            rx_ready = nonempty;
        end
    end
endmodule

// File: rtl/rxq_errtag_fifo.sv
// Receive queue for one UART channel, each entry tagged with parity,
// framing and break bits. Assumes a receiver delivers at most one entry
// per cycle and the host pops at most one per cycle.
module rxq_errtag_fifo
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              dma_mode,
    input  logic [1:0]        trig_sel,
    input  logic              clr_strobe,
    input  logic              wr_valid,
    input  logic [RXQ_DW-1:0] wr_data,
    input  logic              wr_perr,
    input  logic              wr_ferr,
    input  logic              wr_brk,
    input  logic              rd_pop,
    output logic              rd_avail,
    output logic [RXQ_DW-1:0] rd_data,
    output logic              rd_perr,
    output logic              rd_ferr,
    output logic              rd_brk,
    output logic [LW-1:0]     level,
    output logic              trig_hit,
    output logic              any_err,
    output logic              overrun,
    output logic              rx_ready
);
    logic          fifo_en_q;
    logic          flush;
    logic          full;
    logic          push;
    logic          pop;
    logic [LW-1:0] cap;
    rxq_entry_t    wr_entry;
    rxq_entry_t    rd_entry;

    // Remember the previous mode to spot a change.
    always_ff @(posedge clk) begin
        if (!rst_n) fifo_en_q <= 1'b0;
        else        fifo_en_q <= fifo_en;
    end

    // Qualify the strobes against capacity, emptiness and flush.
    always_comb begin
        flush    = (fifo_en != fifo_en_q) || (clr_strobe && fifo_en);
        cap      = fifo_en ? LW'(DEPTH) : LW'(1);
        full     = (level >= cap);
        push     = wr_valid && !full && !flush;
        pop      = rd_pop && (level != '0) && !flush;
        wr_entry = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr, data: wr_data};
    end

    // Sticky overrun: set by a lost write, cleared by a pop or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            overrun <= 1'b0;
        end else if (wr_valid && full) begin
            overrun <= 1'b1;
        end else if (pop) begin
            overrun <= 1'b0;
        end
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (push),
        .pop      (pop),
        .wr_entry (wr_entry),
        .rd_entry (rd_entry),
        .level    (level)
    );

    rxq_errcount #(.DEPTH(DEPTH)) u_errcnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .push_tagged (push && rxq_tagged(wr_entry)),
        .pop_tagged  (pop && rxq_tagged(rd_entry)),
        .any_err     (any_err)
    );

    rxq_dmaready #(.DEPTH(DEPTH)) u_ready (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .fifo_en  (fifo_en),
        .dma_mode (dma_mode),
        .trig_sel (trig_sel),
        .level    (level),
        .trig_hit (trig_hit),
        .rx_ready (rx_ready)
    );

    // Present the oldest entry.
    always_comb begin
        rd_avail = (level != '0);
        rd_data  = rd_entry.data;
        rd_perr  = rd_entry.perr;
        rd_ferr  = rd_entry.ferr;
        rd_brk   = rd_entry.brk;
    end
endmodule

// File: rtl/rxq_errtag_fifo_chk.sv
// Protocol checker for the tagged receive queue, bound to the top module.
module rxq_errtag_fifo_chk #(
    parameter  int DEPTH = 64,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          dma_mode,
    input logic          clr_strobe,
    input logic          wr_valid,
    input logic          rd_pop,
    input logic          flush,
    input logic          full,
    input logic          rd_avail,
    input logic [LW-1:0] level,
    input logic          any_err,
    input logic          overrun,
    input logic          rx_ready
);
    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full && !flush) |=> overrun);

    assert_idle_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && !wr_valid) |=> (level == '0));

    assert_empty_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> !any_err);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_strobe && fifo_en) |=> (level == '0 && !overrun && !any_err));

    assert_single_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> (fifo_en || level <= LW'(1)));

    assert_ready_any_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_avail && !dma_mode) |-> rx_ready);

    assert_ready_drained_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> rd_avail);
endmodule

bind rxq_errtag_fifo rxq_errtag_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .dma_mode   (dma_mode),
    .clr_strobe (clr_strobe),
    .wr_valid   (wr_valid),
    .rd_pop     (rd_pop),
    .flush      (flush),
    .full       (full),
    .rd_avail   (rd_avail),
    .level      (level),
    .any_err    (any_err),
    .overrun    (overrun),
    .rx_ready   (rx_ready)
);

// File: tb/rxq_errtag_fifo_tb.sv
module rxq_errtag_fifo_tb;
    localparam int DEPTH = 64;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 1'b1;
    logic          dma_mode = 1'b0;
    logic [1:0]    trig_sel = 2'd0;
    logic          clr_strobe = 1'b0;
    logic          wr_valid = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          wr_perr = 1'b0, wr_ferr = 1'b0, wr_brk = 1'b0;
    logic          rd_pop = 1'b0;
    logic          rd_avail, rd_perr, rd_ferr, rd_brk;
    logic [7:0]    rd_data;
    logic [LW-1:0] level;
    logic          trig_hit, any_err, overrun, rx_ready;

    rxq_errtag_fifo #(.DEPTH(DEPTH)) u_dut (.*);

    always #2 clk = ~clk;

    logic [10:0] model [$];
    bit          exp_ovr = 1'b0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_cap();
        return fifo_en ? DEPTH : 1;
    endfunction

    function automatic int model_err();
        foreach (model[i]) if (model[i][10:8] != 3'b000) return 1;
        return 0;
    endfunction

    function automatic int thr_of(int sel);
        if (!fifo_en) return 1;
        case (sel)
            0: return DEPTH / 8;
            1: return DEPTH / 4;
            2: return DEPTH / 2;
            default: return DEPTH - DEPTH / 8;
        endcase
    endfunction

    // Driver: one write; the scoreboard expects it queued or lost.
    task automatic push(input logic [10:0] e);
        @(negedge clk);
        wr_valid = 1'b1;
        {wr_brk, wr_ferr, wr_perr, wr_data} = e;
        @(negedge clk);
        wr_valid = 1'b0;
        if (model.size() < model_cap()) model.push_back(e);
        else exp_ovr = 1'b1;
    endtask

    // Monitor: compare the oldest entry against the scoreboard, then pop.
    task automatic pop_cmp(string req);
        logic [10:0] exp_e;
        exp_e = model[0];
        check(req, {rd_brk, rd_ferr, rd_perr, rd_data}, exp_e);
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        void'(model.pop_front());
        exp_ovr = 1'b0;
    endtask

    task automatic state(string req);
        check({req, " level"}, level, model.size());
        check({req, " any_err"}, any_err, model_err());
        check({req, " overrun"}, overrun, exp_ovr);
        check({req, " rd_avail"}, rd_avail, model.size() != 0);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr_strobe = 1'b1;
        @(negedge clk);
        clr_strobe = 1'b0;
        if (fifo_en) begin
            model.delete();
            exp_ovr = 1'b0;
        end
    endtask

    task automatic set_mode(bit fen);
        @(negedge clk);
        if (fifo_en != fen) begin
            model.delete();
            exp_ovr = 1'b0;
        end
        fifo_en = fen;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        state("R1");
        check("R1 rx_ready", rx_ready, 0);

        // R2 / R10: order and ready in single-transfer behaviour
        push(11'h012); push(11'h034); push(11'h056);
        state("R2");
        check("R10 ready", rx_ready, 1);
        for (int i = 0; i < 3; i++) pop_cmp("R2 order");
        check("R10 ready empty", rx_ready, 0);

        // R5: tagged entry between clean ones
        push(11'h0A1); push(11'h2B2); push(11'h0C3);
        check("R5 any_err", any_err, 1);
        pop_cmp("R5 clean");
        check("R5 still tagged", any_err, 1);
        pop_cmp("R5 tagged");
        check("R5 cleared", any_err, 0);
        pop_cmp("R5 last");

        // R2: simultaneous push and pop
        push(11'h111);
        @(negedge clk);
        rd_pop = 1'b1; wr_valid = 1'b1; {wr_brk, wr_ferr, wr_perr, wr_data} = 11'h422;
        @(negedge clk);
        rd_pop = 1'b0; wr_valid = 1'b0;
        void'(model.pop_front()); model.push_back(11'h422);
        state("R2 push+pop");
        pop_cmp("R2 push+pop data");

        // R6 / R3: fill to capacity, check every threshold at every level
        for (int i = 0; i < DEPTH; i++) begin
            push({(i % 7 == 3) ? 3'b010 : 3'b000, 8'(i * 3 + 1)});
            for (int s = 0; s < 4; s++) begin
                trig_sel = 2'(s);
                #0.5;
                check("R6 trig_hit", trig_hit, (model.size() >= thr_of(s)) ? 1 : 0);
            end
        end
        state("R3 full");
        push(11'h7FF);
        state("R3 overrun");
        pop_cmp("R3 oldest kept");
        check("R3 overrun cleared by pop", overrun, 0);
        while (model.size() > 0) pop_cmp("R2 drain");
        state("R2 drained");

        // R4: pop on empty
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
        state("R4");

        // R11: block-transfer ready with threshold 8
        dma_mode = 1'b1; trig_sel = 2'd0;
        for (int i = 0; i < 7; i++) push(11'(i));
        check("R11 below threshold", rx_ready, 0);
        push(11'h008);
        check("R11 at threshold", rx_ready, 1);
        for (int i = 0; i < 5; i++) pop_cmp("R11 drain");
        check("R11 held below threshold", rx_ready, 1);
        while (model.size() > 1) pop_cmp("R11 drain");
        check("R11 last entry", rx_ready, 1);
        pop_cmp("R11 drain");
        check("R11 empty", rx_ready, 0);
        push(11'h099);
        check("R11 rearmed", rx_ready, 0);
        dma_mode = 1'b0;

        // R7: clear in buffered mode
        push(11'h4AA); push(11'h0BB);
        pulse_clr();
        state("R7 clear");

        // R9: mode change discards contents
        push(11'h0CC); push(11'h1DD);
        set_mode(1'b0);
        state("R9 switch");

        // R8: single-slot capacity, threshold 1
        push(11'h0E1);
        check("R8 trig", trig_hit, 1);
        push(11'h0E2);
        state("R8 overrun");
        pulse_clr();
        state("R7 ignored");
        pop_cmp("R8 first kept");
        dma_mode = 1'b1;
        push(11'h0F3);
        check("R10 single-slot ready", rx_ready, 1);
        pop_cmp("R8 data");
        set_mode(1'b1);
        state("R9 back");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule